// File: doc/BRIEF.md
# Audio codec control register file

This block is the control and status register bank of an audio codec. An upstream link decoder drives it through a plain synchronous port: a write strobe with address and data, and a read strobe whose data comes back one clock later with a valid flag. The address is a 7-bit byte index. Only even indexes select 16-bit registers, which gives 64 register slots.

The bank holds the following registers:
- a variable-rate enable register;
- two sample-rate registers, one for the DAC path and one for the ADC path, each holding the rate in Hz as a plain binary number;
- a powerdown control and status register;
- an identity register that reports the strap pins with inverted polarity;
- two fixed vendor words.

Every other slot is reserved. A reserved slot ignores writes and reads as zero.

The control bits and the effective sample rates leave the block as plain outputs for the codec datapath. The ready flags of the analog power sequencer come in as plain inputs. A cold reset (`rst_ni` low) restores every default. A one-cycle warm reset pulse clears only the link powerdown bit.

Top module: `codec_reg_file`

## Requirements
- R1: After cold reset, register 2Ah reads 0000h, registers 2Ch and 32h read BB80h, and bits 15:8 of register 26h read 0. The rate outputs are 48000 and `pd_ctrl_o` is 0.
- R2: A read strobe in cycle N gives `rvalid_o` high in cycle N+1 only. `rdata_o` then holds the register value at the strobe edge.
- R3: Register 2Ah bit 0 is the read/write variable-rate enable and drives `vra_en_o`. Bits 15:1 of 2Ah read 0.
- R4: Registers 2Ch and 32h are read/write. A written value below 4000 is stored as 4000 (0FA0h). A written value above 48000 is stored as 48000 (BB80h). Any other value is stored unchanged.
- R5: While the variable-rate enable is 0, `dac_rate_o` and `adc_rate_o` are 48000 whatever is stored. While it is 1, they equal the stored 2Ch and 32h values.
- R6: Register 28h has the following fixed layout, and writes to it are ignored:
  - bit 15 reads ~`id_pins_n_i[1]`;
  - bit 14 reads ~`id_pins_n_i[0]`;
  - bit 0 reads 1;
  - all other bits read 0.
- R7: Register 7Ch reads 4E53h and register 7Eh reads 4349h. Writes to both are ignored.
- R8: Every address other than 26h, 28h, 2Ah, 2Ch, 32h, 7Ch and 7Eh is reserved, including all odd addresses. A reserved address reads 0000h, and a write to it changes no register.
- R9: Register 26h has the following layout:
  - bits 15:8 are read/write controls, with `pd_ctrl_o[k]` equal to bit 8+k;
  - bit 14 (unused) always reads 0;
  - bits 7:4 read 0;
  - bits 3:0 read `pd_ready_i`, and writes to them are ignored.
- R10: A one-cycle `warm_rst_i` pulse clears bit 12 of 26h (`pd_ctrl_o[4]`, the link powerdown) and leaves every other register bit unchanged. It wins over a write to 26h in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset pulse |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 7 | Register byte index |
| wdata_i | input | 16 | Write data |
| id_pins_n_i | input | 2 | Identity strap pins, active low |
| pd_ready_i | input | 4 | Analog subsection ready flags |
| rdata_o | output | 16 | Read data, one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |
| vra_en_o | output | 1 | Variable-rate enable |
| dac_rate_o | output | 16 | Effective DAC sample rate in Hz |
| adc_rate_o | output | 16 | Effective ADC sample rate in Hz |
| pd_ctrl_o | output | 8 | Powerdown controls, bits 15:8 of 26h |

## Verification
The bench writes all-ones, all-zeros and alternating patterns to all 128 indexes and reads every one of them back against an arithmetic model. This catches the following faults:
- a decoder that aliases odd indexes onto registers;
- a reserved slot that stores data;
- a read-only word that takes a write;
- an unused bit 14 that stores data.

Rate writes at 0, 3999, 4000, 4001, 47999, 48000, 48001 and FFFFh find an off-by-one or inverted clamp. Toggling the variable-rate enable around stored rates shows whether stored values leak to the outputs too early. All four strap combinations check the identity inversion. The warm reset tests run alone and in the same cycle as a 26h write. They expose a design that clears more than the link bit, or that lets the write win.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  localparam logic [6:0] ADR_PWR  = 7'h26;
  localparam logic [6:0] ADR_ID   = 7'h28;
  localparam logic [6:0] ADR_EXT  = 7'h2A;
  localparam logic [6:0] ADR_DAC  = 7'h2C;
  localparam logic [6:0] ADR_ADC  = 7'h32;
  localparam logic [6:0] ADR_VID0 = 7'h7C;
  localparam logic [6:0] ADR_VID1 = 7'h7E;
  localparam logic [15:0] VID0_VAL = 16'h4E53;
  localparam logic [15:0] VID1_VAL = 16'h4349;
  localparam int N_RATE = 2;  // 0: DAC, 1: ADC
endpackage

// File: rtl/rate_reg.sv
module rate_reg #(
  parameter int DW  = 16,
  parameter int MIN = 4000,
  parameter int MAX = 48000,
  parameter int DEF = 48000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          vra_i,
  output logic [DW-1:0] stored_o,
  output logic [DW-1:0] eff_o
);
  localparam logic [DW-1:0] MIN_V = DW'(MIN);
  localparam logic [DW-1:0] MAX_V = DW'(MAX);
  localparam logic [DW-1:0] DEF_V = DW'(DEF);

  logic [DW-1:0] clamped;

  always_comb begin
    if (wdata_i < MIN_V)      clamped = MIN_V;
    else if (wdata_i > MAX_V) clamped = MAX_V;
    else                      clamped = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stored_o <= DEF_V;
    else if (we_i) stored_o <= clamped;
  end

  // stored value takes effect only in variable-rate mode
  assign eff_o = vra_i ? stored_o : DEF_V;

  // R4
  rate_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_o >= MIN_V) && (stored_o <= MAX_V));

  // R4
  rate_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i >= MIN_V && wdata_i <= MAX_V) |=> stored_o == $past(wdata_i));
endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg #(
  parameter int CW         = 8,
  parameter int UNUSED_BIT = 6,
  parameter int LINK_BIT   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          warm_i,
  output logic [CW-1:0] ctrl_o
);
  localparam logic [CW-1:0] UNUSED_M = CW'(1) << UNUSED_BIT;
  localparam logic [CW-1:0] LINK_M   = CW'(1) << LINK_BIT;

  logic [CW-1:0] nxt;

  always_comb begin
    nxt = we_i ? (wdata_i & ~UNUSED_M) : ctrl_o;
    if (warm_i) nxt = nxt & ~LINK_M;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else         ctrl_o <= nxt;
  end

  // R10
  warm_clears_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_i |=> !ctrl_o[LINK_BIT]);

  // R10
  warm_keeps_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_i && !we_i) |=> (ctrl_o & ~LINK_M) == ($past(ctrl_o) & ~LINK_M));

  // R9
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[UNUSED_BIT]);
endmodule

// File: rtl/read_mux.sv
module read_mux
  import codec_reg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] pwr_i,
  input  logic [DW-1:0] id_i,
  input  logic [DW-1:0] ext_i,
  input  logic [DW-1:0] dac_i,
  input  logic [DW-1:0] adc_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DW-1:0] sel;

  always_comb begin
    unique case (addr_i)
      ADR_PWR:  sel = pwr_i;
      ADR_ID:   sel = id_i;
      ADR_EXT:  sel = ext_i;
      ADR_DAC:  sel = dac_i;
      ADR_ADC:  sel = adc_i;
      ADR_VID0: sel = VID0_VAL;
      ADR_VID1: sel = VID1_VAL;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= sel;
    end
  end

  // R2
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  // R2
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  // R7
  vid0_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADR_VID0) |=> rdata_o == 16'h4E53);
  // R8
  odd_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[0]) |=> rdata_o == '0);
endmodule

// File: rtl/codec_reg_file.sv
module codec_reg_file
  import codec_reg_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 7,
  parameter int RATE_MIN = 4000,
  parameter int RATE_MAX = 48000,
  parameter int RATE_DEF = 48000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    id_pins_n_i,
  input  logic [3:0]    pd_ready_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          vra_en_o,
  output logic [DW-1:0] dac_rate_o,
  output logic [DW-1:0] adc_rate_o,
  output logic [7:0]    pd_ctrl_o
);
  localparam int CW = 8;
  localparam logic [AW-1:0] RATE_ADR [N_RATE] = '{ADR_DAC, ADR_ADC};

  logic          vra_q;
  logic [DW-1:0] stored [N_RATE];
  logic [DW-1:0] eff    [N_RATE];
  logic [DW-1:0] pwr_word, id_word, ext_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          vra_q <= 1'b0;
    else if (wr_en_i && addr_i == ADR_EXT) vra_q <= wdata_i[0];
  end

  for (genvar g = 0; g < N_RATE; g++) begin : g_rate
    rate_reg #(.DW(DW), .MIN(RATE_MIN), .MAX(RATE_MAX), .DEF(RATE_DEF)) u_rate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && addr_i == RATE_ADR[g]),
      .wdata_i (wdata_i),
      .vra_i   (vra_q),
      .stored_o(stored[g]),
      .eff_o   (eff[g])
    );
  end

  pwr_ctrl_reg #(.CW(CW), .UNUSED_BIT(6), .LINK_BIT(4)) u_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i && addr_i == ADR_PWR),
    .wdata_i(wdata_i[DW-1:DW-CW]),
    .warm_i (warm_rst_i),
    .ctrl_o (pd_ctrl_o)
  );

  assign pwr_word = {pd_ctrl_o, 4'b0000, pd_ready_i};
  // identity reported with inverted pin polarity; bit 0 flags variable rate support
  assign id_word  = {~id_pins_n_i, {(DW-3){1'b0}}, 1'b1};
  assign ext_word = {{(DW-1){1'b0}}, vra_q};

  read_mux #(.DW(DW), .AW(AW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .pwr_i   (pwr_word),
    .id_i    (id_word),
    .ext_i   (ext_word),
    .dac_i   (stored[0]),
    .adc_i   (stored[1]),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  assign vra_en_o   = vra_q;
  assign dac_rate_o = eff[0];
  assign adc_rate_o = eff[1];

  // R6
  id_invert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADR_ID) |=> rdata_o[15:14] == ~$past(id_pins_n_i));

  // R5
  rate_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vra_en_o) |-> (dac_rate_o == DW'(RATE_DEF) && adc_rate_o == DW'(RATE_DEF)));
endmodule

// File: tb/tb_codec_reg_file.sv
module tb_codec_reg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  pins = 2'b11;
  logic [3:0]  ready = 4'h0;
  logic [15:0] rdata, dac_o, adc_o;
  logic        rvalid, vra_o;
  logic [7:0]  pd_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic        m_vra;
  logic [15:0] m_dac, m_adc;
  logic [7:0]  m_pd;

  always #4 clk = ~clk;

  codec_reg_file dut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .id_pins_n_i(pins), .pd_ready_i(ready),
    .rdata_o(rdata), .rvalid_o(rvalid), .vra_en_o(vra_o),
    .dac_rate_o(dac_o), .adc_rate_o(adc_o), .pd_ctrl_o(pd_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] clamp(logic [15:0] v);
    if (v < 16'd4000) return 16'd4000;
    if (v > 16'd48000) return 16'd48000;
    return v;
  endfunction

  function automatic logic [15:0] model_rd(logic [6:0] a);
    case (a)
      7'h26:   return {m_pd, 4'h0, ready};
      7'h28:   return {~pins, 13'h0, 1'b1};
      7'h2A:   return {15'h0, m_vra};
      7'h2C:   return m_dac;
      7'h32:   return m_adc;
      7'h7C:   return 16'h4E53;
      7'h7E:   return 16'h4349;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(logic [6:0] a);
    case (a)
      7'h26:        return "R9";
      7'h28:        return "R6";
      7'h2A:        return "R3";
      7'h2C, 7'h32: return "R4";
      7'h7C, 7'h7E: return "R7";
      default:      return "R8";
    endcase
  endfunction

  task automatic model_wr(logic [6:0] a, logic [15:0] d);
    case (a)
      7'h26: m_pd = d[15:8] & 8'hBF;
      7'h2A: m_vra = d[0];
      7'h2C: m_dac = clamp(d);
      7'h32: m_adc = clamp(d);
      default: ;
    endcase
  endtask

  task automatic do_wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_rd(logic [6:0] a, string tag);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    chk("R2 rvalid", {15'h0, rvalid}, 16'h1);
    chk(tag, rdata, model_rd(a));
  endtask

  task automatic sweep_read();
    for (int a = 0; a < 128; a++) do_rd(7'(a), tag_of(7'(a)));
  endtask

  task automatic chk_outputs(string tag);
    chk({tag, " vra_en_o"}, {15'h0, vra_o}, {15'h0, m_vra});
    chk({tag, " dac_rate_o"}, dac_o, m_vra ? m_dac : 16'd48000);
    chk({tag, " adc_rate_o"}, adc_o, m_vra ? m_adc : 16'd48000);
    chk({tag, " pd_ctrl_o"}, {8'h0, pd_o}, {8'h0, m_pd});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] pats [3] = '{16'hFFFF, 16'h0000, 16'hA5A5};
    logic [15:0] rates [8] = '{16'd0, 16'd3999, 16'd4000, 16'd4001,
                               16'd47999, 16'd48000, 16'd48001, 16'hFFFF};
    m_vra = 0; m_dac = 16'd48000; m_adc = 16'd48000; m_pd = 8'h00;
    ready = 4'h5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_outputs("R1");
    sweep_read();
    do_rd(7'h2C, "R1 dac default");
    do_rd(7'h32, "R1 adc default");

    // R2 rvalid is a single-cycle pulse
    @(negedge clk);
    chk("R2 rvalid low", {15'h0, rvalid}, 16'h0);

    // R8 R6 R7 R9 R3 full-address write sweeps
    foreach (pats[p]) begin
      for (int a = 0; a < 128; a++) do_wr(7'(a), pats[p] ^ 16'(a));
      sweep_read();
      chk_outputs("R3 R9 sweep");
    end

    // R6 identity inversion over all pin straps
    for (int pv = 0; pv < 4; pv++) begin
      pins = 2'(pv);
      do_rd(7'h28, "R6");
    end
    // R9 ready flags
    for (int rv = 0; rv < 16; rv++) begin
      ready = 4'(rv);
      do_rd(7'h26, "R9");
    end

    // R5 stored but not effective while variable rate is off
    do_wr(7'h2A, 16'h0000);
    do_wr(7'h2C, 16'd8000);
    do_wr(7'h32, 16'd11025);
    chk_outputs("R5 off");
    do_rd(7'h2C, "R5 stored dac");
    do_wr(7'h2A, 16'h0001);
    chk_outputs("R5 on");
    chk("R5 dac 8000", dac_o, 16'd8000);

    // R4 clamp boundaries on both rate registers
    foreach (rates[i]) begin
      do_wr(7'h2C, rates[i]);
      do_wr(7'h32, ~rates[i]);
      do_rd(7'h2C, "R4 dac");
      do_rd(7'h32, "R4 adc");
      chk_outputs("R4");
    end

    // R10 warm reset clears only link powerdown
    do_wr(7'h26, 16'hFF00);
    chk("R9 unused bit", {8'h0, pd_o}, 16'h00BF);
    @(negedge clk); warm = 1'b1;
    @(negedge clk); warm = 1'b0;
    m_pd[4] = 1'b0;
    chk("R10 pd_ctrl_o", {8'h0, pd_o}, 16'h00AF);
    chk_outputs("R10");
    sweep_read();

    // R10 warm reset beats a same-cycle write
    @(negedge clk);
    warm = 1'b1; wr = 1'b1; addr = 7'h26; wdata = 16'h1300;
    @(negedge clk);
    warm = 1'b0; wr = 1'b0;
    m_pd = 8'h03;
    chk("R10 with write", {8'h0, pd_o}, 16'h0003);
    do_rd(7'h26, "R10 readback");

    // R1 cold reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_vra = 0; m_dac = 16'd48000; m_adc = 16'd48000; m_pd = 8'h00;
    chk_outputs("R1 cold");
    do_rd(7'h2C, "R1 dac");
    do_rd(7'h32, "R1 adc");
    do_rd(7'h26, "R1 pwr");
    do_rd(7'h2A, "R1 ext");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule